// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode state machine of a small microcontroller. It moves the chip between Run, Deepsleep and Standby. The decision is taken when the core signals a sleep request, which is tagged as wait-for-interrupt or wait-for-event. The core's deep-sleep flag, a standby-select control bit and a latched wakeup flag then choose the target mode. The block drives enables for the regulator, the core supply domain, the PLL, the internal RC oscillator and the crystal oscillator. It also drives a system-clock-on indication, a system reset pulse and the pad high-impedance controls.

Deepsleep keeps the core domain powered. The mode ends on an interrupt line when it was entered by wait-for-interrupt, and on an event line when it was entered by wait-for-event. The way out is sequenced. If the regulator was in its low-power setting, a regulator settle window runs first. An RC oscillator settle window follows, and only then is the clock switched back in. Standby removes power from everything except the always-on logic. It ends on a reset request, on one of four clock-calendar events, or on the enabled wakeup pin. Leaving Standby issues a system reset and latches the wakeup flag.

Software controls the block through three 32-bit registers that accept word accesses only.

Top module: `lpm_seq`

## Requirements
- R1: After reset, mode is Run (mode=0). Regulator, core domain and RC oscillator are enabled, and the system clock is on. The PLL and crystal enables are low, and no pad is high-impedance. The second control register reads 0x00000080 and the other two registers read 0.
- R2: A sleep request with deep_bit=1 and standby-select=0 moves the block to Deepsleep (mode=1) on the next clock. Deepsleep switches off the PLL, both oscillators and the system clock, and it clears the PLL-on and crystal-on bits. A sleep request with deep_bit=0 has no effect.
- R3: Standby (mode=2) is entered on the next clock only when four conditions hold together: a sleep request, deep_bit=1, standby-select=1 and a clear wakeup flag. When the wakeup flag is set, the request leaves the block in Run.
- R4: A Deepsleep entered with slp_wfe=0 ends only when an irq_lines bit is set. A Deepsleep entered with slp_wfe=1 ends only when an evt_lines bit is set. Activity on the other class of lines is ignored.
- R5: On a Deepsleep wake, the block shows mode=3 for REG_WAIT cycles if low-power-regulator was 1. In that window ldo_lp=0 and rc_en=0. The block then shows mode=3 for OSC_WAIT cycles with rc_en=1 and sysclk_on=0, and then returns to Run with sysclk_on=1. With low-power-regulator=0 the first window is skipped. During Deepsleep, ldo_lp follows the low-power-regulator bit.
- R6: Wake activity during either settle window neither restarts nor lengthens it.
- R7: In Standby, ldo_en, core_en, pll_en, rc_en and xtal_en are all 0, and pad_hiz=1. tamper_hiz=1 unless the tamper-keep bit is set, and wkpin_hiz=1 unless the wakeup-pin enable is set.
- R8: Standby ends on ext_rst_req or wdt_rst_req high at a clock edge. It also ends on a rising edge of rtc_periodic, rtc_stamp, rtc_tamper, rtc_alarm, or wkup_pin when the wakeup-pin enable is set. Each of these edge inputs passes two synchronizer flops, so the exit happens on the third clock edge after the input rises. A wkup_pin edge with the enable clear is ignored.
- R9: Leaving Standby gives exactly one cycle with sys_rst=1 and mode=3, and then Run. In that cycle every register field returns to its reset value except the wakeup flag, which is set.
- R10: Writing 1 to bit 2 of the control register clears the wakeup flag. The bit itself reads as 0.
- R11: The register map is as follows. Offset 0x00 holds the control register: bit0 low-power-regulator, bit1 standby-select, bit2 flag-clear. Offset 0x04 holds the status register: bit0 wakeup flag (read-only), bit8 wakeup-pin enable. Offset 0x20 holds the second control register: bit0 PLL-on, bit1 crystal-on, bit7 tamper-keep. Only accesses with bus_size=2'b10 take effect. Any other size, and any unmapped offset, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| slp_req | input | 1 | One-cycle sleep request from the core |
| slp_wfe | input | 1 | 1: request is wait-for-event, 0: wait-for-interrupt |
| deep_bit | input | 1 | Core deep-sleep flag |
| irq_lines | input | NLINES | External lines configured as interrupts |
| evt_lines | input | NLINES | External lines configured as events |
| ext_rst_req | input | 1 | External reset pin request, active high, synchronous |
| wdt_rst_req | input | 1 | Watchdog reset request, active high, synchronous |
| rtc_periodic | input | 1 | Clock-calendar periodic wake, asynchronous |
| rtc_stamp | input | 1 | Clock-calendar timestamp event, asynchronous |
| rtc_tamper | input | 1 | Clock-calendar tamper event, asynchronous |
| rtc_alarm | input | 1 | Clock-calendar alarm, asynchronous |
| wkup_pin | input | 1 | Wakeup pin, asynchronous |
| bus_en | input | 1 | Register access valid |
| bus_we | input | 1 | 1: write, 0: read |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | Access size, 2'b10 is a word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| mode | output | 2 | 0 Run, 1 Deepsleep, 2 Standby, 3 transition |
| ldo_en | output | 1 | Regulator enable |
| ldo_lp | output | 1 | Regulator low-power setting |
| core_en | output | 1 | Core supply domain enable |
| pll_en | output | 1 | PLL enable |
| rc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| sysclk_on | output | 1 | RC clock switched in as system clock |
| sys_rst | output | 1 | System reset pulse on Standby exit |
| pad_hiz | output | 1 | General pads high-impedance |
| tamper_hiz | output | 1 | Tamper pads high-impedance |
| wkpin_hiz | output | 1 | Wakeup pin pad high-impedance |

## Verification
Deepsleep is entered through both request tags, and each time a line of the wrong class is driven before the right one. This shows that the wake-class choice follows the tag. The exit is run with the low-power-regulator bit both clear and set, and wake activity is injected inside the windows, to expose a missing, reordered or restartable regulator window. Standby is left once through every wake source in turn. Standby is also tried with the wakeup flag set, and with a pin edge while the pin enable is clear, to separate the four-condition entry and the pin gating from plain sleep handling. Word, non-word and unmapped accesses check that only correct word accesses reach the registers.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int NLINES   = 4,
  parameter int REG_WAIT = 4,
  parameter int OSC_WAIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slp_req,
  input  logic              slp_wfe,
  input  logic              deep_bit,
  input  logic [NLINES-1:0] irq_lines,
  input  logic [NLINES-1:0] evt_lines,
  input  logic              ext_rst_req,
  input  logic              wdt_rst_req,
  input  logic              rtc_periodic,
  input  logic              rtc_stamp,
  input  logic              rtc_tamper,
  input  logic              rtc_alarm,
  input  logic              wkup_pin,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        mode,
  output logic              ldo_en,
  output logic              ldo_lp,
  output logic              core_en,
  output logic              pll_en,
  output logic              rc_en,
  output logic              xtal_en,
  output logic              sysclk_on,
  output logic              sys_rst,
  output logic              pad_hiz,
  output logic              tamper_hiz,
  output logic              wkpin_hiz
);
  localparam int WMAX = (REG_WAIT > OSC_WAIT) ? REG_WAIT : OSC_WAIT;
  localparam int CW   = $clog2(WMAX + 1);

  typedef enum logic [2:0] {S_RUN, S_DEEP, S_WREG, S_WOSC, S_STBY, S_XRST} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic lp_reg, stby_sel, wk_flag, wkup_en, pll_on, xtal_on, tamper_keep, wfe_q;
  logic [4:0] s1, s2, s3;

  wire [4:0] async_in = {wkup_pin, rtc_alarm, rtc_tamper, rtc_stamp, rtc_periodic};
  wire [4:0] rise     = s2 & ~s3;
  wire stby_wake = ext_rst_req | wdt_rst_req | (|rise[3:0]) | (rise[4] & wkup_en);
  wire deep_wake = wfe_q ? (|evt_lines) : (|irq_lines);
  wire word      = (bus_size == 2'b10);
  wire wr        = bus_en & bus_we & word;
  wire rd        = bus_en & ~bus_we & word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RUN;
      cnt         <= '0;
      lp_reg      <= 1'b0;
      stby_sel    <= 1'b0;
      wk_flag     <= 1'b0;
      wkup_en     <= 1'b0;
      pll_on      <= 1'b0;
      xtal_on     <= 1'b0;
      tamper_keep <= 1'b1;
      wfe_q       <= 1'b0;
    end else begin
      if (wr) begin
        case (bus_addr)
          8'h00: begin
            lp_reg   <= bus_wdata[0];
            stby_sel <= bus_wdata[1];
            if (bus_wdata[2]) wk_flag <= 1'b0;
          end
          8'h04: wkup_en <= bus_wdata[8];
          8'h20: begin
            pll_on      <= bus_wdata[0];
            xtal_on     <= bus_wdata[1];
            tamper_keep <= bus_wdata[7];
          end
          default: ;
        endcase
      end
      case (st)
        S_RUN:
          if (slp_req && deep_bit) begin
            if (stby_sel) begin
              if (!wk_flag) st <= S_STBY;
            end else begin
              st      <= S_DEEP;
              wfe_q   <= slp_wfe;
              pll_on  <= 1'b0;
              xtal_on <= 1'b0;
            end
          end
        S_DEEP:
          if (deep_wake) begin
            cnt <= '0;
            st  <= lp_reg ? S_WREG : S_WOSC;
          end
        S_WREG:
          if (cnt == CW'(REG_WAIT - 1)) begin
            cnt <= '0;
            st  <= S_WOSC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_WOSC:
          if (cnt == CW'(OSC_WAIT - 1)) begin
            cnt <= '0;
            st  <= S_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_STBY:
          if (stby_wake) begin
            st          <= S_XRST;
            wk_flag     <= 1'b1;
            lp_reg      <= 1'b0;
            stby_sel    <= 1'b0;
            wkup_en     <= 1'b0;
            pll_on      <= 1'b0;
            xtal_on     <= 1'b0;
            tamper_keep <= 1'b1;
          end
        default: st <= S_RUN;
      endcase
    end
  end

  wire in_run  = (st == S_RUN);
  wire in_deep = (st == S_DEEP);
  wire in_stby = (st == S_STBY);

  assign mode = in_run ? 2'd0 : in_deep ? 2'd1 : in_stby ? 2'd2 : 2'd3;

  assign ldo_en     = ~in_stby;
  assign core_en    = ~in_stby;
  assign ldo_lp     = in_deep & lp_reg;
  assign pll_en     = in_run & pll_on;
  assign xtal_en    = in_run & xtal_on;
  assign rc_en      = in_run | (st == S_WOSC) | (st == S_XRST);
  assign sysclk_on  = in_run;
  assign sys_rst    = (st == S_XRST);
  assign pad_hiz    = in_stby;
  assign tamper_hiz = in_stby & ~tamper_keep;
  assign wkpin_hiz  = in_stby & ~wkup_en;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        8'h00:   bus_rdata = {30'd0, stby_sel, lp_reg};
        8'h04:   bus_rdata = {23'd0, wkup_en, 7'd0, wk_flag};
        8'h20:   bus_rdata = {24'd0, tamper_keep, 5'd0, xtal_on, pll_on};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module lpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slp_req,
  input logic       deep_bit,
  input logic [1:0] mode,
  input logic       ldo_en,
  input logic       core_en,
  input logic       pll_en,
  input logic       rc_en,
  input logic       xtal_en,
  input logic       sysclk_on,
  input logic       sys_rst,
  input logic       pad_hiz
);
  a_r7_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!ldo_en && !core_en && !pll_en && !rc_en && !xtal_en && pad_hiz));

  a_r5_clock_needs_rc: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_on |-> rc_en);

  a_r9_reset_after_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ($past(mode) == 2'd2));

  a_r9_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  a_r3_standby_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_hiz) |-> $past(slp_req && deep_bit));

  a_r2_deep_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(slp_req && deep_bit));
endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .deep_bit(deep_bit), .mode(mode),
  .ldo_en(ldo_en), .core_en(core_en), .pll_en(pll_en), .rc_en(rc_en), .xtal_en(xtal_en),
  .sysclk_on(sysclk_on), .sys_rst(sys_rst), .pad_hiz(pad_hiz)
);

// File: tb/lpm_seq_tb.sv
`timescale 1ns/1ps
module lpm_seq_tb;
  localparam int NL = 4, RW = 4, OW = 6;

  logic clk = 0, rst_n = 0;
  logic slp_req = 0, slp_wfe = 0, deep_bit = 0;
  logic [NL-1:0] irq_lines = 0, evt_lines = 0;
  logic ext_rst_req = 0, wdt_rst_req = 0;
  logic rtc_periodic = 0, rtc_stamp = 0, rtc_tamper = 0, rtc_alarm = 0, wkup_pin = 0;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_size = 2'b10;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] mode;
  logic ldo_en, ldo_lp, core_en, pll_en, rc_en, xtal_en, sysclk_on, sys_rst, pad_hiz, tamper_hiz, wkpin_hiz;

  always #2.5 clk = ~clk;

  lpm_seq #(.NLINES(NL), .REG_WAIT(RW), .OSC_WAIT(OW)) u_dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  string cur = "R1";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run,1 deep,2 reg settle,3 osc settle,4 standby,5 reset pulse
  int ms, mc;
  bit lp, sb, fl, we, pl, hx, tk, wf;
  bit [4:0] q1, q2, q3;

  always @(posedge clk or negedge rst_n) begin
    bit olp, osb, ofl, owe;
    bit [4:0] rise;
    bit wake;
    if (!rst_n) begin
      ms = 0; mc = 0; lp = 0; sb = 0; fl = 0; we = 0; pl = 0; hx = 0; tk = 1; wf = 0;
      q1 = 0; q2 = 0; q3 = 0;
    end else begin
      olp = lp; osb = sb; ofl = fl; owe = we;
      rise = q2 & ~q3;
      q3 = q2; q2 = q1;
      q1 = {wkup_pin, rtc_alarm, rtc_tamper, rtc_stamp, rtc_periodic};
      if (bus_en && bus_we && bus_size == 2'b10) begin
        if (bus_addr == 8'h00) begin
          lp = bus_wdata[0]; sb = bus_wdata[1];
          if (bus_wdata[2]) fl = 0;
        end else if (bus_addr == 8'h04) we = bus_wdata[8];
        else if (bus_addr == 8'h20) begin
          pl = bus_wdata[0]; hx = bus_wdata[1]; tk = bus_wdata[7];
        end
      end
      if (ms == 0) begin
        if (slp_req && deep_bit) begin
          if (osb) begin
            if (!ofl) ms = 4;
          end else begin
            ms = 1; wf = slp_wfe; pl = 0; hx = 0;
          end
        end
      end else if (ms == 1) begin
        wake = wf ? (evt_lines != 0) : (irq_lines != 0);
        if (wake) begin mc = 0; ms = olp ? 2 : 3; end
      end else if (ms == 2) begin
        mc++; if (mc == RW) begin mc = 0; ms = 3; end
      end else if (ms == 3) begin
        mc++; if (mc == OW) begin mc = 0; ms = 0; end
      end else if (ms == 4) begin
        wake = ext_rst_req || wdt_rst_req || (rise[3:0] != 0) || (rise[4] && owe);
        if (wake) begin
          ms = 5; fl = 1; lp = 0; sb = 0; we = 0; pl = 0; hx = 0; tk = 1;
        end
      end else ms = 0;
    end
  end

  function automatic logic [12:0] exp_out();
    logic [1:0] m;
    bit run, st;
    m = (ms == 0) ? 2'd0 : (ms == 1) ? 2'd1 : (ms == 4) ? 2'd2 : 2'd3;
    run = (ms == 0); st = (ms == 4);
    return {m, !st, (ms == 1) && lp, !st, run && pl, run || ms == 3 || ms == 5,
            run && hx, run, ms == 5, st, st && !tk, st && !we};
  endfunction

  function automatic logic [31:0] exp_rd();
    if (!(bus_en && !bus_we && bus_size == 2'b10)) return 0;
    case (bus_addr)
      8'h00:   return {30'd0, sb, lp};
      8'h04:   return {23'd0, we, 7'd0, fl};
      8'h20:   return {24'd0, tk, 5'd0, hx, pl};
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({cur, " outputs"}, {19'd0, mode, ldo_en, ldo_lp, core_en, pll_en, rc_en, xtal_en,
          sysclk_on, sys_rst, pad_hiz, tamper_hiz, wkpin_hiz}, {19'd0, exp_out()});
      chk({cur, " rdata"}, bus_rdata, exp_rd());
    end
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [1:0] sz = 2'b10);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    tick(1);
    bus_en = 0; bus_we = 0; bus_size = 2'b10;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag, logic [1:0] sz = 2'b10);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #1;
    chk(tag, bus_rdata, e);
    tick(1);
    bus_en = 0; bus_size = 2'b10;
  endtask

  task automatic sleep(bit deep, bit wfe);
    slp_req = 1; deep_bit = deep; slp_wfe = wfe;
    tick(1);
    slp_req = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    cur = "R1";
    chk("R1 mode", mode, 0);
    chk("R1 sysclk", sysclk_on, 1);
    rd(8'h20, 32'h80, "R1 ctrl2 reset");
    rd(8'h00, 0, "R1 ctrl reset");
    rd(8'h04, 0, "R1 status reset");

    cur = "R2";
    sleep(0, 0);
    chk("R2 no deep without deep_bit", mode, 0);
    wr(8'h20, 32'h83);
    rd(8'h20, 32'h83, "R11 ctrl2 write");
    sleep(1, 0);
    chk("R2 deep entered", mode, 1);
    chk("R2 pll off", pll_en, 0);
    cur = "R4";
    evt_lines = 4'b0010; tick(2); evt_lines = 0;
    chk("R4 event ignored after wfi", mode, 1);
    irq_lines = 4'b1000; tick(1); irq_lines = 0;
    cur = "R5";
    chk("R5 osc wait", mode, 3);
    chk("R5 rc on", rc_en, 1);
    tick(OW);
    chk("R5 back to run", mode, 0);
    rd(8'h20, 32'h80, "R2 pll and crystal bits cleared");

    cur = "R5";
    wr(8'h00, 32'h1);
    sleep(1, 1);
    chk("R5 low-power regulator in deep", ldo_lp, 1);
    cur = "R4";
    irq_lines = 4'b0001; tick(2); irq_lines = 0;
    chk("R4 irq ignored after wfe", mode, 1);
    evt_lines = 4'b0100; tick(1); evt_lines = 0;
    cur = "R6";
    chk("R5 regulator window rc off", rc_en, 0);
    tick(2);
    evt_lines = 4'b1111; irq_lines = 4'b1111; tick(1); evt_lines = 0; irq_lines = 0;
    tick(RW - 3);
    chk("R6 osc window started", rc_en, 1);
    evt_lines = 4'b0001; tick(1); evt_lines = 0;
    tick(OW - 2);
    chk("R6 last osc cycle", mode, 3);
    tick(1);
    chk("R6 run after fixed windows", mode, 0);

    cur = "R11";
    wr(8'h00, 32'h2, 2'b01);
    rd(8'h00, 32'h1, "R11 non-word write ignored");
    rd(8'h20, 0, "R11 non-word read zero", 2'b01);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 0, "R11 unmapped read zero");
    rd(8'h04, 0, "R11 status unchanged");

    cur = "R8";
    wr(8'h00, 32'h2);
    wr(8'h20, 32'h0);
    sleep(1, 0);
    chk("R7 standby", mode, 2);
    chk("R7 tamper pad hiz", tamper_hiz, 1);
    wkup_pin = 1; tick(6); wkup_pin = 0; tick(4);
    chk("R8 disabled pin ignored", mode, 2);
    rtc_alarm = 1; tick(3);
    cur = "R9";
    chk("R9 reset pulse", sys_rst, 1);
    rtc_alarm = 0; tick(1);
    chk("R9 run after reset", mode, 0);
    rd(8'h04, 32'h1, "R9 flag set");
    rd(8'h20, 32'h80, "R9 ctrl2 reset value");

    cur = "R3";
    wr(8'h00, 32'h2);
    sleep(1, 0);
    chk("R3 standby blocked by flag", mode, 0);
    cur = "R10";
    wr(8'h00, 32'h6);
    rd(8'h04, 0, "R10 flag cleared");
    rd(8'h00, 32'h2, "R10 clear bit reads zero");

    for (int src = 0; src < 7; src++) begin
      cur = "R8";
      wr(8'h00, 32'h6);
      if (src == 6) wr(8'h04, 32'h100);
      sleep(1, src[0]);
      chk("R3 standby entered", mode, 2);
      if (src == 6) chk("R7 enabled pin driven", wkpin_hiz, 0);
      tick(2);
      case (src)
        0: ext_rst_req = 1;
        1: wdt_rst_req = 1;
        2: rtc_periodic = 1;
        3: rtc_stamp = 1;
        4: rtc_tamper = 1;
        5: rtc_alarm = 1;
        default: wkup_pin = 1;
      endcase
      tick(1);
      ext_rst_req = 0; wdt_rst_req = 0;
      tick(3);
      rtc_periodic = 0; rtc_stamp = 0; rtc_tamper = 0; rtc_alarm = 0; wkup_pin = 0;
      tick(3);
      chk("R8 standby left", mode, 0);
      rd(8'h04, 32'h1, "R9 flag after wake");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule